// File: doc/BRIEF.md
# Configuration Request Header Engine

The engine sends one PCIe type 0 configuration read or configuration write request on behalf of a CPU. Software composes three header dwords and, for a write, one data dword in a small register bank. Setting the go bit in the control register starts the request. The engine then streams the header, followed by the payload when there is one, as 32-bit beats on a valid/ready outbound port.

After the last beat the engine waits for a completion from the far side. When the completion arrives it records the 3-bit completion status. For a successful read it also latches the returned dword. It then drops the go bit, so software can poll a single register to see both the end of the request and its outcome.

If no completion comes back within a programmable number of cycles, the engine ends the request by itself and reports an all-ones status. While a request is in flight, the header and data registers are frozen.

Top module: `cfgtlp_engine`

## Requirements
- R1: The register port decodes aligned byte addresses: header word 0 at 0x00, header word 1 at 0x04, header word 2 at 0x08, write data at 0x0C, control at 0x10, read data at 0x14 (read only) and timeout limit at 0x18. A selected access raises reg_ack in the next cycle, and read data is valid in that same cycle.
- R2: Writing control with bit 0 set while idle starts a request. Control bit 0 reads 1 until the request ends. Control bits 7:5 (status) read 0 from the start of the request until its end.
- R3: Header word 0 carries length in bits 9:0 (1), type in bits 28:24 (4, a type 0 configuration request) and format in bits 31:29 (3'b000 read, 3'b010 write). The beats go out as header 0, header 1, header 2, then the write-data word only when bit 30 of header word 0 is set. tx_last marks the final beat.
- R4: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values.
- R5: A completion presented after the last beat is accepted. In the next cycle control bit 0 reads 0 and bits 7:5 hold the completion status, where any nonzero value means failure.
- R6: The read-data register takes the completion dword only for a read request that completes with status 0. A write completion or a failed read leaves it unchanged. Software obtains a sub-dword value by shifting it right by 8 times the two low offset bits.
- R7: Writes to the header, write-data, limit and control registers are ignored while a request is in flight. The beats sent and the values read back afterwards are those programmed before the start.
- R8: If no completion arrives within limit+1 waiting cycles, the request ends with status 3'b111, control bit 0 cleared and the read-data register unchanged.
- R9: Header words 1 and 2 are sent bit-exact. Word 1 bits 3:0 hold a run of 1s as long as the access size (1, 2 or 4 bytes) shifted left by the two low offset bits. Word 2 holds the register number in bits 11:2, function in 18:16, device in 23:19 and bus in 31:24. The write word is sent exactly as programmed, already shifted left by 8 times the offset bits.
- R10: A completion presented while the engine is idle has no effect on the status bits or the read-data register.
- R11: After reset, tx_valid is 0, control and read data read 0, and the limit reads its parameter default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_ack |
| reg_ack | output | 1 | Access response, one cycle after reg_sel |
| tx_valid | output | 1 | Outbound beat valid |
| tx_ready | input | 1 | Outbound beat accepted |
| tx_data | output | 32 | Outbound beat data |
| tx_last | output | 1 | Final beat of the request |
| cpl_valid | input | 1 | Completion strobe |
| cpl_status | input | 3 | Completion status |
| cpl_data | input | 32 | Completion payload dword |

## Verification
The hardest situations to reach from the ports are register writes that land while a request is in flight, and a completion whose status or timing falls at a boundary. The stimulus holds tx_ready low after a start and issues writes to every frozen register during that window. It then releases random back-pressure and compares each beat and the register read-backs against the values programmed before the start. Completion delays are drawn at random below the limit, with further cases for a zero delay, a silent far side that must hit the timeout, and a completion offered while idle.

// File: rtl/cfgtlp_pkg.sv
package cfgtlp_pkg;

    localparam int WORD_W    = 32;
    localparam int STAT_W    = 3;
    localparam int HDR_WORDS = 3;
    localparam int IDX_W     = 2;

    localparam logic [STAT_W-1:0] STAT_TIMEOUT = 3'b111;

    // register word indices (byte address / 4)
    localparam int RI_HDR0  = 0;
    localparam int RI_HDR1  = 1;
    localparam int RI_HDR2  = 2;
    localparam int RI_WDATA = 3;
    localparam int RI_CTRL  = 4;
    localparam int RI_RDATA = 5;
    localparam int RI_LIMIT = 6;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SEND = 2'd1,
        SQ_WAIT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              last;
    } beat_t;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [WORD_W-1:0] data;
    } cpl_t;

    // format bit 30 set means the request carries a data dword
    function automatic logic has_payload(input logic [WORD_W-1:0] h0);
        return h0[30];
    endfunction

    function automatic logic [IDX_W-1:0] final_index(input logic [WORD_W-1:0] h0);
        return has_payload(h0) ? IDX_W'(HDR_WORDS) : IDX_W'(HDR_WORDS - 1);
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_image(input logic [STAT_W-1:0] st,
                                                      input logic busy);
        logic [WORD_W-1:0] w;
        w      = '0;
        w[7:5] = st;
        w[0]   = busy;
        return w;
    endfunction

endpackage

// File: rtl/cfgtlp_regs.sv
module cfgtlp_regs
    import cfgtlp_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int TMO_W    = 16,
    parameter int TMO_INIT = 1000
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              reg_sel,
    input  logic                              reg_wr,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic [WORD_W-1:0]                 reg_wdata,
    output logic [WORD_W-1:0]                 reg_rdata,
    output logic                              reg_ack,
    input  logic                              busy,
    input  logic [STAT_W-1:0]                 status,
    input  logic [WORD_W-1:0]                 rd_word,
    output logic [HDR_WORDS-1:0][WORD_W-1:0]  hdr,
    output logic [WORD_W-1:0]                 pay,
    output logic [TMO_W-1:0]                  limit,
    output logic                              start
);

    localparam int IW = ADDR_W - 2;

    logic [IW-1:0] idx;
    logic          aligned;
    logic          wr_ok;

    assign idx     = reg_addr[ADDR_W-1:2];
    assign aligned = (reg_addr[1:0] == 2'b00);
    assign wr_ok   = reg_sel && reg_wr && aligned && !busy;
    assign start   = wr_ok && (idx == IW'(RI_CTRL)) && reg_wdata[0];

    genvar g;
    generate
        for (g = 0; g < HDR_WORDS; g++) begin : g_hdr
            always_ff @(posedge clk) begin
                if (rst)
                    hdr[g] <= '0;
                else if (wr_ok && idx == IW'(RI_HDR0 + g))
                    hdr[g] <= reg_wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pay   <= '0;
            limit <= TMO_W'(TMO_INIT);
        end else if (wr_ok) begin
            if (idx == IW'(RI_WDATA)) pay   <= reg_wdata;
            if (idx == IW'(RI_LIMIT)) limit <= reg_wdata[TMO_W-1:0];
        end
    end

    logic [WORD_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        if (aligned) begin
            case (idx)
                IW'(RI_HDR0):  rd_mux = hdr[0];
                IW'(RI_HDR1):  rd_mux = hdr[1];
                IW'(RI_HDR2):  rd_mux = hdr[2];
                IW'(RI_WDATA): rd_mux = pay;
                IW'(RI_CTRL):  rd_mux = ctrl_image(status, busy);
                IW'(RI_RDATA): rd_mux = rd_word;
                IW'(RI_LIMIT): rd_mux = WORD_W'(limit);
                default:       rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_ack   <= 1'b0;
            reg_rdata <= '0;
        end else begin
            reg_ack <= reg_sel;
            if (reg_sel && !reg_wr)
                reg_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/cfgtlp_tmo.sv
module cfgtlp_tmo #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    logic [TMO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt != {TMO_W{1'b1}})
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt >= limit);

endmodule

// File: rtl/cfgtlp_seq.sv
module cfgtlp_seq
    import cfgtlp_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start,
    input  logic [HDR_WORDS-1:0][WORD_W-1:0]  hdr,
    input  logic [WORD_W-1:0]                 pay,
    input  logic                              tx_ready,
    output beat_t                             beat,
    output logic                              beat_valid,
    input  logic                              cpl_valid,
    input  cpl_t                              cpl,
    input  logic                              expired,
    output logic                              busy,
    output logic                              waiting,
    output logic [STAT_W-1:0]                 status,
    output logic [WORD_W-1:0]                 rd_word
);

    seq_state_e      state;
    logic [IDX_W-1:0] bidx;
    logic [IDX_W-1:0] fin;

    assign fin        = final_index(hdr[0]);
    assign busy       = (state != SQ_IDLE);
    assign waiting    = (state == SQ_WAIT);
    assign beat_valid = (state == SQ_SEND);

    always_comb begin
        beat.last = beat_valid && (bidx == fin);
        if (bidx < IDX_W'(HDR_WORDS))
            beat.data = hdr[bidx];
        else
            beat.data = pay;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            bidx    <= '0;
            status  <= '0;
            rd_word <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state  <= SQ_SEND;
                        bidx   <= '0;
                        status <= '0;
                    end
                end
                SQ_SEND: begin
                    if (tx_ready) begin
                        if (bidx == fin)
                            state <= SQ_WAIT;
                        else
                            bidx <= bidx + 1'b1;
                    end
                end
                SQ_WAIT: begin
                    if (cpl_valid) begin
                        state  <= SQ_IDLE;
                        status <= cpl.status;
                        if (!has_payload(hdr[0]) && cpl.status == '0)
                            rd_word <= cpl.data;
                    end else if (expired) begin
                        state  <= SQ_IDLE;
                        status <= STAT_TIMEOUT;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfgtlp_engine.sv
module cfgtlp_engine
    import cfgtlp_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int TMO_W    = 16,
    parameter int TMO_INIT = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_ack,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [31:0]       tx_data,
    output logic              tx_last,
    input  logic              cpl_valid,
    input  logic [2:0]        cpl_status,
    input  logic [31:0]       cpl_data
);

    logic [HDR_WORDS-1:0][WORD_W-1:0] hdr;
    logic [WORD_W-1:0]                pay;
    logic [TMO_W-1:0]                 limit;
    logic                             start;
    logic                             busy;
    logic                             waiting;
    logic                             expired;
    logic [STAT_W-1:0]                status;
    logic [WORD_W-1:0]                rd_word;
    beat_t                            beat;
    cpl_t                             cpl;

    assign cpl.status = cpl_status;
    assign cpl.data   = cpl_data;
    assign tx_data    = beat.data;
    assign tx_last    = beat.last;

    cfgtlp_regs #(
        .ADDR_W   (ADDR_W),
        .TMO_W    (TMO_W),
        .TMO_INIT (TMO_INIT)
    ) i_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_ack   (reg_ack),
        .busy      (busy),
        .status    (status),
        .rd_word   (rd_word),
        .hdr       (hdr),
        .pay       (pay),
        .limit     (limit),
        .start     (start)
    );

    cfgtlp_seq i_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .hdr        (hdr),
        .pay        (pay),
        .tx_ready   (tx_ready),
        .beat       (beat),
        .beat_valid (tx_valid),
        .cpl_valid  (cpl_valid),
        .cpl        (cpl),
        .expired    (expired),
        .busy       (busy),
        .waiting    (waiting),
        .status     (status),
        .rd_word    (rd_word)
    );

    cfgtlp_tmo #(
        .TMO_W (TMO_W)
    ) i_tmo (
        .clk     (clk),
        .rst     (rst),
        .run     (waiting),
        .limit   (limit),
        .expired (expired)
    );

endmodule

// File: rtl/cfgtlp_engine_chk.sv
module cfgtlp_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_sel,
    input logic        reg_ack,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [31:0] tx_data,
    input logic        tx_last,
    input logic        cpl_valid,
    input logic [2:0]  cpl_status,
    input logic        busy,
    input logic        waiting,
    input logic        expired,
    input logic [2:0]  status,
    input logic [95:0] hdr_flat
);

    // R1: one-cycle response
    a_r1_ack_follows: assert property (@(posedge clk) disable iff (rst)
        reg_sel |=> reg_ack);
    a_r1_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
        !reg_sel |=> !reg_ack);

    // R4: back-pressure holds the beat
    a_r4_hold_beat: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R3: the final beat hands over to waiting
    a_r3_last_to_wait: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last) |=> (waiting && !tx_valid));

    // R5: accepted completion ends the request with its status
    a_r5_cpl_done: assert property (@(posedge clk) disable iff (rst)
        (waiting && cpl_valid) |=> (!busy && status == $past(cpl_status)));

    // R8: timeout ends the request with all-ones status
    a_r8_timeout: assert property (@(posedge clk) disable iff (rst)
        (waiting && expired && !cpl_valid) |=> (!busy && status == 3'b111));

    // R7: header words frozen while in flight
    a_r7_hdr_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(hdr_flat));

    // R10: idle completion leaves status alone
    a_r10_idle_cpl: assert property (@(posedge clk) disable iff (rst)
        (!busy && cpl_valid) |=> $stable(status));

endmodule

bind cfgtlp_engine cfgtlp_engine_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_sel    (reg_sel),
    .reg_ack    (reg_ack),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .cpl_valid  (cpl_valid),
    .cpl_status (cpl_status),
    .busy       (busy),
    .waiting    (waiting),
    .expired    (expired),
    .status     (status),
    .hdr_flat   (hdr)
);

// File: tb/test_cfgtlp_engine.sv
module test_cfgtlp_engine;

    localparam int LIMIT = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_ack;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [31:0] tx_data;
    logic        tx_last;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_status = '0;
    logic [31:0] cpl_data = '0;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;
    logic [31:0] model_rd = '0;

    always #10 clk = ~clk;

    cfgtlp_engine i_cfgtlp_engine (
        .clk(clk), .rst(rst),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_data(cpl_data)
    );

    function automatic logic [31:0] mk_hdr0(input bit is_wr);
        return {(is_wr ? 3'b010 : 3'b000), 5'd4, 14'd0, 10'd1};
    endfunction

    function automatic logic [31:0] mk_hdr1(input int size, input logic [1:0] off);
        logic [3:0] run;
        run = (size == 1) ? 4'b0001 : (size == 2) ? 4'b0011 : 4'b1111;
        return {28'd0, 4'(run << off)};
    endfunction

    function automatic logic [31:0] mk_hdr2(input logic [7:0] bus, input logic [4:0] dev,
                                            input logic [2:0] fn, input logic [9:0] dw);
        return {bus, dev, fn, 4'd0, dw, 2'b00};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_sel = 0; reg_wr = 0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        reg_sel = 1; reg_wr = 0; reg_addr = a;
        tick();
        reg_sel = 0;
        d = reg_rdata;
    endtask

    task automatic do_req(input bit is_wr, input logic [7:0] bus, input logic [4:0] dev,
                          input logic [2:0] fn, input logic [9:0] dw, input int size,
                          input logic [1:0] off, input logic [31:0] val,
                          input logic [2:0] cst, input logic [31:0] cdat,
                          input int dly, input bit tmo, input bit poke);
        logic [31:0] exp_b [4];
        logic [31:0] r;
        int nb, got, guard;
        exp_b[0] = mk_hdr0(is_wr);
        exp_b[1] = mk_hdr1(size, off);
        exp_b[2] = mk_hdr2(bus, dev, fn, dw);
        exp_b[3] = val << (8 * off);
        nb = is_wr ? 4 : 3;
        reg_write(8'h00, exp_b[0]);
        reg_write(8'h04, exp_b[1]);
        reg_write(8'h08, exp_b[2]);
        reg_write(8'h0C, exp_b[3]);
        reg_write(8'h10, 32'h1);
        reg_read(8'h10, r);
        chk("R2 go bit set, status clear", r, 32'h1);
        if (poke) begin
            reg_write(8'h00, ~exp_b[0]);
            reg_write(8'h04, 32'hF);
            reg_write(8'h08, 32'hDEADBEEF);
            reg_write(8'h0C, 32'h12345678);
            reg_write(8'h18, 32'd3);
            reg_write(8'h10, 32'h1);
        end
        got = 0;
        guard = 0;
        while (got < nb && guard < 200) begin
            tx_ready = 1'($urandom % 2);
            if (tx_valid && tx_ready) begin
                chk(is_wr ? "R3 R9 write beat" : "R3 R9 read beat", tx_data, exp_b[got]);
                chk("R3 last flag", 32'(tx_last), 32'(got == nb - 1));
                got++;
            end
            tick();
            guard++;
        end
        tx_ready = 0;
        chk("R3 beat count", 32'(got), 32'(nb));
        chk("R3 no beat while waiting", 32'(tx_valid), 32'd0);
        if (!tmo) begin
            repeat (dly) tick();
            cpl_valid = 1; cpl_status = cst; cpl_data = cdat;
            tick();
            cpl_valid = 0;
            reg_read(8'h10, r);
            chk("R5 completion status, go cleared", r, {24'd0, cst, 5'd0});
            if (!is_wr && cst == 3'd0) model_rd = cdat;
        end else begin
            repeat (LIMIT + 3) tick();
            reg_read(8'h10, r);
            chk("R8 timeout status", r, 32'h0000_00E0);
        end
        reg_read(8'h14, r);
        chk("R6 read data register", r, model_rd);
        if (!is_wr && cst == 3'd0 && !tmo) begin
            logic [31:0] m;
            m = (size == 1) ? 32'hFF : (size == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
            chk("R6 sub-dword extract", (r >> (8 * off)) & m, (cdat >> (8 * off)) & m);
        end
        if (poke) begin
            reg_read(8'h00, r);
            chk("R7 header 0 kept", r, exp_b[0]);
            reg_read(8'h08, r);
            chk("R7 header 2 kept", r, exp_b[2]);
            reg_read(8'h18, r);
            chk("R7 limit kept", r, 32'(LIMIT));
        end
    endtask

    initial begin
        logic [31:0] r;
        void'($urandom(32'd7));
        repeat (3) tick();
        rst = 0;
        tick();
        // R11 reset state
        chk("R11 tx_valid after reset", 32'(tx_valid), 32'd0);
        reg_read(8'h10, r);
        chk("R11 control after reset", r, 32'd0);
        reg_read(8'h14, r);
        chk("R11 read data after reset", r, 32'd0);
        reg_read(8'h18, r);
        chk("R11 limit default", r, 32'd1000);
        // R1 register access and ack timing
        reg_write(8'h18, 32'(LIMIT));
        chk("R1 ack after write", 32'(reg_ack), 32'd1);
        reg_read(8'h18, r);
        chk("R1 limit readback", r, 32'(LIMIT));
        reg_write(8'h0C, 32'hA5A5_0001);
        reg_read(8'h0C, r);
        chk("R1 write-data readback", r, 32'hA5A5_0001);
        tick();
        chk("R1 ack drops", 32'(reg_ack), 32'd0);

        // directed corners
        do_req(0, 8'h00, 5'd0, 3'd0, 10'd0, 4, 2'd0, 32'h0, 3'd0, 32'h1234_5678, 0, 0, 0);
        do_req(0, 8'hFF, 5'd31, 3'd7, 10'h3FF, 1, 2'd3, 32'h0, 3'd0, 32'hAB00_0000, 5, 0, 0);
        do_req(1, 8'h01, 5'd2, 3'd1, 10'd4, 2, 2'd2, 32'hBEEF, 3'd0, 32'hFFFF_FFFF, 3, 0, 0);
        do_req(0, 8'h02, 5'd3, 3'd0, 10'd16, 4, 2'd0, 32'h0, 3'd1, 32'h5555_5555, 2, 0, 0);
        do_req(0, 8'h03, 5'd1, 3'd2, 10'd8, 2, 2'd0, 32'h0, 3'd0, 32'h0, 0, 1, 0);
        do_req(1, 8'h04, 5'd5, 3'd3, 10'd9, 1, 2'd1, 32'h77, 3'd0, 32'h0, 1, 0, 1);

        // R10 idle completion ignored
        cpl_valid = 1; cpl_status = 3'd5; cpl_data = 32'hCAFE_F00D;
        tick();
        cpl_valid = 0;
        reg_read(8'h10, r);
        chk("R10 idle completion status", r, 32'd0);
        reg_read(8'h14, r);
        chk("R10 idle completion data", r, model_rd);

        // random requests
        for (int i = 0; i < 30; i++) begin
            int sz;
            logic [1:0] of;
            sz = (i % 3 == 0) ? 4 : (i % 3 == 1) ? 2 : 1;
            of = (sz == 4) ? 2'd0 : (sz == 2) ? 2'($urandom % 2) * 2'd2 : 2'($urandom % 4);
            do_req(1'($urandom % 2), 8'($urandom), 5'($urandom), 3'($urandom), 10'($urandom),
                   sz, of, $urandom, ($urandom % 4 == 0) ? 3'($urandom) : 3'd0, $urandom,
                   int'($urandom % 16), 0, (i % 7 == 0));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule